// File: doc/BRIEF.md
# Serial Bus Hold Pause Controller

This block lets a host pause a serial flash transaction in the middle, without ending it, by pulling an active-low hold pin low. It samples the serial clock, the active-low chip select, the hold pin and a flag that marks a four-lane transfer, all on the system clock. From them it derives a hold state. That state freezes the transaction shifters and puts the serial data output into high impedance. The shifters and any program or erase engine are outside this block. They only see the freeze and the data-output gating, so an internal write operation keeps running while the bus is paused.

A pause begins on a falling edge of the hold pin and ends on a rising edge. Each transition takes effect only while the serial clock is low. If the serial clock is high at the edge, the request is held in a pending flag until the clock goes low. Raising chip select during a pause aborts the transaction and locks the interface. The lock is released only by a falling edge of chip select taken while the hold pin is high. During a four-lane transfer the hold pin carries data, so hold handling is switched off.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After synchronous reset, hold_active_o=0, shift_en_o=0, so_hiz_o=1 and abort_o=0, including when reset is applied during a pause.
- R2: With chip select low and no four-lane transfer, a falling edge of the hold pin sampled while the serial clock is low sets hold_active_o one system clock after the edge is sampled.
- R3: A hold-pin falling edge sampled while the serial clock is high is held pending, and the pause begins one cycle after the serial clock is sampled low. If the hold pin returns high before that, the pending entry is dropped and no pause occurs.
- R4: During a pause, a rising edge of the hold pin sampled while the serial clock is low clears hold_active_o one cycle later.
- R5: A hold-pin rising edge sampled while the serial clock is high is held pending, and the pause ends one cycle after the serial clock is sampled low. If the hold pin falls again first, the pending exit is dropped and the pause continues.
- R6: While paused, shift_en_o=0 and so_hiz_o=1, and serial clock toggles change neither output.
- R7: Hold-pin edges while chip select is high have no effect. A hold pin that is already low when chip select falls does not start a pause.
- R8: Chip select rising during a pause clears the pause and raises abort_o for exactly one cycle. Chip select rising with only an entry pending clears that pending entry without an abort.
- R9: After an abort, shift_en_o stays 0 and so_hiz_o stays 1 until chip select falls while the hold pin is high. A chip select fall with the hold pin low leaves the lock in place.
- R10: While quad_io_i=1, hold-pin edges are ignored, and a pause in progress is released one cycle later.
- R11: With chip select low and no pause or lock, shift_en_o=1 and so_hiz_o=0. With chip select high, shift_en_o=0 and so_hiz_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock level |
| cs_n_i | input | 1 | Active-low chip select |
| hold_n_i | input | 1 | Active-low hold request pin |
| quad_io_i | input | 1 | High while a four-lane transfer uses the hold pin as data |
| hold_active_o | output | 1 | Pause in effect |
| shift_en_o | output | 1 | Enable for shifters and bit counters |
| so_hiz_o | output | 1 | Serial data output must float |
| abort_o | output | 1 | One-cycle pulse when a pause is aborted by chip select |

## Verification
The bench targets the deferred transitions. A design that ignores the serial clock level would enter or leave the pause a cycle too early. A design that forgets to cancel its pending flags would pause after the hold pin had already returned high, or would resume after the pin fell again. Stale pending state is probed across a chip select rise: a design that keeps it would enter a pause with no new edge. The lock after an abort is tested with a chip select fall while the hold pin is low, which a careless design would treat as a new transaction. The four-lane mode is tested both against new edges and against a pause already in progress.

// File: rtl/hold_pause_pkg.sv
package hold_pause_pkg;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic hold_n;
        logic quad;
    } pin_t;

    typedef struct packed {
        logic hold_fall;
        logic hold_rise;
        logic cs_fall;
        logic cs_rise;
    } edge_t;

    typedef enum logic [1:0] {
        HS_RUN  = 2'd0,
        HS_HOLD = 2'd1,
        HS_LOCK = 2'd2
    } hstate_e;

    localparam pin_t PIN_IDLE = '{sclk: 1'b0, cs_n: 1'b1, hold_n: 1'b1, quad: 1'b0};

    function automatic edge_t find_edges(pin_t now, pin_t old);
        edge_t e;
        e.hold_fall = old.hold_n & ~now.hold_n;
        e.hold_rise = ~old.hold_n & now.hold_n;
        e.cs_fall   = old.cs_n & ~now.cs_n;
        e.cs_rise   = ~old.cs_n & now.cs_n;
        return e;
    endfunction

endpackage

// File: rtl/hold_pin_sampler.sv
module hold_pin_sampler
    import hold_pause_pkg::*;
#(
    parameter int SYNC_STAGES = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  pin_t  raw,
    output pin_t  cur,
    output edge_t edges
);

    pin_t prev_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign cur = raw;
        end else begin : g_sync
            pin_t chain_q [SYNC_STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < SYNC_STAGES; i++) chain_q[i] <= PIN_IDLE;
                end else begin
                    chain_q[0] <= raw;
                    for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
                end
            end
            assign cur = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PIN_IDLE;
        else     prev_q <= cur;
    end

    assign edges = find_edges(cur, prev_q);

endmodule

// File: rtl/hold_state_fsm.sv
module hold_state_fsm
    import hold_pause_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pin_t    pins,
    input  edge_t   edges,
    output hstate_e state,
    output logic    abort_pulse
);

    hstate_e state_q, state_d;
    logic    pend_in_q, pend_in_d;
    logic    pend_out_q, pend_out_d;
    logic    abort_d;

    always_comb begin
        state_d    = state_q;
        pend_in_d  = pend_in_q;
        pend_out_d = pend_out_q;
        abort_d    = 1'b0;
        if (pins.cs_n) begin
            pend_in_d  = 1'b0;
            pend_out_d = 1'b0;
            if (state_q == HS_HOLD) begin
                state_d = HS_LOCK;
                abort_d = 1'b1;
            end
        end else if (state_q == HS_LOCK) begin
            if (edges.cs_fall && pins.hold_n) state_d = HS_RUN;
        end else if (pins.quad) begin
            state_d    = HS_RUN;
            pend_in_d  = 1'b0;
            pend_out_d = 1'b0;
        end else if (state_q == HS_RUN) begin
            if (!pins.hold_n && (edges.hold_fall || pend_in_q)) begin
                if (!pins.sclk) begin
                    state_d   = HS_HOLD;
                    pend_in_d = 1'b0;
                end else begin
                    pend_in_d = 1'b1;
                end
            end else begin
                pend_in_d = 1'b0;
            end
        end else begin
            if (pins.hold_n && (edges.hold_rise || pend_out_q)) begin
                if (!pins.sclk) begin
                    state_d    = HS_RUN;
                    pend_out_d = 1'b0;
                end else begin
                    pend_out_d = 1'b1;
                end
            end else begin
                pend_out_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= HS_RUN;
            pend_in_q   <= 1'b0;
            pend_out_q  <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            state_q     <= state_d;
            pend_in_q   <= pend_in_d;
            pend_out_q  <= pend_out_d;
            abort_pulse <= abort_d;
        end
    end

    assign state = state_q;

    AST_ENTRY_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_HOLD && $past(state_q) != HS_HOLD) |-> !$past(pins.sclk)); // R3
    AST_EXIT_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_RUN && $past(state_q) == HS_HOLD && !$past(pins.quad)) |-> !$past(pins.sclk)); // R5
    AST_ABORT_LOCKS: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> state_q == HS_LOCK); // R8
    AST_QUAD_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pins.quad && !pins.cs_n) |=> state_q != HS_HOLD); // R10
    AST_PEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(pend_in_q && pend_out_q)); // R5

endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
    import hold_pause_pkg::*;
#(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic hold_n_i,
    input  logic quad_io_i,
    output logic hold_active_o,
    output logic shift_en_o,
    output logic so_hiz_o,
    output logic abort_o
);

    pin_t    raw_pins, cur_pins;
    edge_t   pin_edges;
    hstate_e st;

    assign raw_pins = '{sclk: sclk_i, cs_n: cs_n_i, hold_n: hold_n_i, quad: quad_io_i};

    hold_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_pins),
        .cur   (cur_pins),
        .edges (pin_edges)
    );

    hold_state_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .pins        (cur_pins),
        .edges       (pin_edges),
        .state       (st),
        .abort_pulse (abort_o)
    );

    assign hold_active_o = (st == HS_HOLD);
    assign shift_en_o    = (st == HS_RUN) && !cur_pins.cs_n;
    assign so_hiz_o      = (st != HS_RUN) || cur_pins.cs_n;

    AST_NO_SHIFT_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold_active_o |-> !shift_en_o); // R6
    AST_HIZ_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold_active_o |-> so_hiz_o); // R6
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o); // R8

endmodule

// File: tb/hold_pause_ctrl_tb.sv
module hold_pause_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst;
    logic sclk, cs_n, hold_n, quad;
    logic hold_act, shift_en, so_hiz, abort_p;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #5 clk = ~clk;

    hold_pause_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .sclk_i        (sclk),
        .cs_n_i        (cs_n),
        .hold_n_i      (hold_n),
        .quad_io_i     (quad),
        .hold_active_o (hold_act),
        .shift_en_o    (shift_en),
        .so_hiz_o      (so_hiz),
        .abort_o       (abort_p)
    );

    // {cs_n, hold_n, sclk, quad, exp_hold, exp_shift, exp_hiz, exp_abort}
    localparam int NVEC = 41;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1100_0010, 8'b0100_0100, 8'b0110_0100, 8'b0000_1010,
        8'b0010_1010, 8'b0000_1010, 8'b0100_0100, 8'b0110_0100,
        8'b0010_0100, 8'b0010_0100, 8'b0000_1010, 8'b0010_1010,
        8'b0110_1010, 8'b0100_0100, 8'b0110_0100, 8'b0010_0100,
        8'b0110_0100, 8'b0100_0100, 8'b0000_1010, 8'b0110_1010,
        8'b0010_1010, 8'b0000_1010, 8'b1000_0011, 8'b1000_0010,
        8'b0000_0010, 8'b1000_0010, 8'b1100_0010, 8'b0100_0100,
        8'b1000_0010, 8'b0000_0100, 8'b0101_0100, 8'b0001_0100,
        8'b0100_0100, 8'b0000_1010, 8'b0001_0100, 8'b0000_0100,
        8'b1100_0010, 8'b0110_0100, 8'b0010_0100, 8'b1000_0010,
        8'b0000_0100
    };

    function automatic string vec_req(int i);
        if (i <= 2)  return "R11";
        if (i <= 5)  return "R2_R6";
        if (i <= 7)  return "R4";
        if (i <= 11) return "R3";
        if (i <= 14) return "R5";
        if (i <= 17) return "R3";
        if (i <= 21) return "R5";
        if (i <= 23) return "R8";
        if (i <= 27) return "R9";
        if (i <= 29) return "R7";
        if (i <= 35) return "R10";
        return "R8";
    endfunction

    task automatic check(string req, logic [3:0] got, logic [3:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {hold,shift,hiz,abort} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(logic c, logic h, logic s, logic q);
        cs_n = c; hold_n = h; sclk = s; quad = q;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; cs_n = 1'b1; hold_n = 1'b1; sclk = 1'b0; quad = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {hold_act, shift_en, so_hiz, abort_p}, 4'b0010);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            check(vec_req(i), {hold_act, shift_en, so_hiz, abort_p}, VEC[i][3:0]);
        end
        // R1: reset during a pause
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R2", {hold_act, shift_en, so_hiz, abort_p}, 4'b1010);
        rst = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check("R1", {hold_act, shift_en, so_hiz, abort_p}, 4'b0010);
        rst = 1'b0;
        // R6: long clock toggling during a pause
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 1'b0, k[0], 1'b0);
            check("R6", {hold_act, shift_en, so_hiz, abort_p}, 4'b1010);
        end
        // R8: abort pulse width, then R9 unlock
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R8", {hold_act, shift_en, so_hiz, abort_p}, 4'b0011);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check("R8", {hold_act, shift_en, so_hiz, abort_p}, 4'b0010);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        check("R9", {hold_act, shift_en, so_hiz, abort_p}, 4'b0100);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule